// File: doc/BRIEF.md
# Core Clock Gate with Interrupt Wake

This block decides whether the processor core receives clock cycles. Software asks for the core clock to stop by writing a stop command. The block then waits until the core reports that its current instruction is complete, and only then drops the clock-enable. Any interrupt line that is asserted and enabled in the mask brings the clock-enable back on the next edge. The interrupt can be of either kind, because the block sees only request levels.

The block uses clock-enable gating. Its own clock never stops, so it can always sample the interrupt lines. The enable affects only the core. Other bus masters keep running and their transfers go on while the core is idle. Software has a write-only command register and a read-only status register to work with.

Top module: `ccg_top`

## Requirements
- R1: After a synchronous reset, `core_ce` is 1, status bit 0 reads 1, and no stop request is pending.
- R2: A write with bit `STOP_BIT` (bit 0 by default) of `wr_data` at 1 requests a stop. A write with that bit at 0 has no effect, whatever the other bits hold.
- R3: A stop request stays pending until an edge where `insn_done` is sampled high, after the write cycle. `core_ce` is 0 from that edge on, and `insn_done` high in the write cycle itself does not count.
- R4: While stopped, any line with `irq_req[i] & irq_mask[i]` high sets `core_ce` to 1 at the next edge.
- R5: An enabled interrupt while a request is pending cancels the request, and the core clock never stops. The wake wins over an `insn_done` in the same cycle.
- R6: A stop write that arrives while an enabled interrupt is asserted is dropped, and `core_ce` stays 1.
- R7: An interrupt line whose mask bit is 0 neither wakes the core nor cancels a request.
- R8: With `rd_addr` = 0, the command register is read, and `rd_data` is all zeros.
- R9: With `rd_addr` = 1, `rd_data` bit 0 equals `core_ce` and all other bits are 0.
- R10: A stop write while the clock is already stopped leaves it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | DW | Command write data |
| rd_addr | input | 1 | Read select: 0 command, 1 status |
| rd_data | output | DW | Read data |
| irq_req | input | NIRQ | Interrupt request levels |
| irq_mask | input | NIRQ | Per-line wake enable |
| insn_done | input | 1 | Core marks an instruction boundary |
| core_ce | output | 1 | Clock-enable for the core |

## Verification
The bench uses the default parameters: eight interrupt lines, a 32-bit data path and the stop command in bit 0. With eight lines, the wake and mask patterns can reach the lowest line, the highest line and lines in the middle, and they can mix enabled and masked lines in one word. The 32-bit data path lets the bench write words that have every bit set except the stop bit. That shows the stop command is decoded only from its own bit position.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

    typedef enum logic [1:0] {
        GATE_RUN   = 2'd0,
        GATE_DRAIN = 2'd1,
        GATE_IDLE  = 2'd2
    } gate_state_t;

    typedef enum logic {
        RSEL_CMD  = 1'b0,
        RSEL_STAT = 1'b1
    } rd_sel_t;

    function automatic logic [31:0] bit_mask(input int unsigned pos);
        return 32'd1 << pos;
    endfunction

endpackage

// File: rtl/ccg_wake.sv
module ccg_wake #(
    parameter int NIRQ = 8
) (
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_mask,
    output logic            wake
);
    logic [NIRQ-1:0] line_hit;

    for (genvar g = 0; g < NIRQ; g++) begin : g_line
        assign line_hit[g] = irq_req[g] & irq_mask[g];
    end

    assign wake = |line_hit;
endmodule

// File: rtl/ccg_cmd.sv
module ccg_cmd #(
    parameter int DW       = 32,
    parameter int STOP_BIT = 0
) (
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          stop_req
);
    localparam logic [DW-1:0] STOP_MASK = DW'(ccg_pkg::bit_mask(STOP_BIT));

    assign stop_req = wr_en & (|(wr_data & STOP_MASK));
endmodule

// File: rtl/ccg_fsm.sv
module ccg_fsm
    import ccg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic stop_req,
    input  logic wake,
    input  logic insn_done,
    output logic core_ce
);
    gate_state_t state_q;
    logic        seen_clk;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATE_RUN;
        end else begin
            case (state_q)
                GATE_RUN:   if (stop_req && !wake) state_q <= GATE_DRAIN;
                GATE_DRAIN: if (wake) state_q <= GATE_RUN;
                            else if (insn_done) state_q <= GATE_IDLE;
                GATE_IDLE:  if (wake) state_q <= GATE_RUN;
                default:    state_q <= GATE_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) seen_clk <= 1'b1;

    assign core_ce = (state_q != GATE_IDLE);

    // Reset leaves the core running (R1)
    assert_reset_run_R1: assert property (@(posedge clk)
        (seen_clk && $past(rst)) |-> (core_ce && state_q == GATE_RUN));

    // The clock only drops right after an instruction boundary (R3)
    assert_stop_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(core_ce) |-> $past(insn_done));

    // Enabled interrupt restarts a stopped core (R4)
    assert_wake_restart_R4: assert property (@(posedge clk) disable iff (rst)
        (!core_ce && wake) |=> core_ce);

    // Pending request is cancelled by a wake (R5)
    assert_cancel_pending_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_DRAIN && wake) |=> (core_ce && state_q == GATE_RUN));

    // Stop write during an enabled interrupt is dropped (R6)
    assert_drop_request_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATE_RUN && stop_req && wake) |=> state_q == GATE_RUN);

    // Without an enabled interrupt a stopped core stays stopped (R7)
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (!core_ce && !wake) |=> !core_ce);
endmodule

// File: rtl/ccg_top.sv
module ccg_top
    import ccg_pkg::*;
#(
    parameter int NIRQ     = 8,
    parameter int DW       = 32,
    parameter int STOP_BIT = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [DW-1:0]   wr_data,
    input  logic            rd_addr,
    output logic [DW-1:0]   rd_data,
    input  logic [NIRQ-1:0] irq_req,
    input  logic [NIRQ-1:0] irq_mask,
    input  logic            insn_done,
    output logic            core_ce
);
    logic wake;
    logic stop_req;

    ccg_wake #(.NIRQ(NIRQ)) u_wake (
        .irq_req  (irq_req),
        .irq_mask (irq_mask),
        .wake     (wake)
    );

    ccg_cmd #(.DW(DW), .STOP_BIT(STOP_BIT)) u_cmd (
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .stop_req (stop_req)
    );

    ccg_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .stop_req  (stop_req),
        .wake      (wake),
        .insn_done (insn_done),
        .core_ce   (core_ce)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel_t'(rd_addr) == RSEL_STAT) rd_data[0] = core_ce;
    end

    // Command register never reads back nonzero (R8)
    assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 1'b0) |-> (rd_data == '0));

    // Status bit mirrors the enable (R9)
    assert_status_mirror_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 1'b1) |-> (rd_data[0] == core_ce && rd_data[DW-1:1] == '0));
endmodule

// File: tb/sim_ccg_top.sv
module sim_ccg_top;
    localparam int NIRQ     = 8;
    localparam int DW       = 32;
    localparam int STOP_BIT = 0;
    localparam int NVEC     = 18;

    // {wr, stop, irq[7:0], mask[7:0], done, expected core_ce after edge}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1},
        {1'b1, 1'b1, 8'h00, 8'h00, 1'b0, 1'b1},
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b1},
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'h04, 8'h00, 1'b0, 1'b0},
        {1'b0, 1'b0, 8'h10, 8'hEF, 1'b0, 1'b0},
        {1'b1, 1'b1, 8'h00, 8'hFF, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'h10, 8'h10, 1'b0, 1'b1},
        {1'b1, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1},
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'h01, 8'h01, 1'b0, 1'b1},
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'h00, 8'h00, 1'b1, 1'b1},
        {1'b0, 1'b0, 8'h80, 8'h80, 1'b1, 1'b1},
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'h20, 8'hDF, 1'b0, 1'b1},
        {1'b0, 1'b0, 8'h00, 8'h00, 1'b1, 1'b0},
        {1'b0, 1'b0, 8'h02, 8'h03, 1'b0, 1'b1}
    };

    function automatic string tag_of(input int idx);
        case (idx)
            0:       return "R1";
            1, 2:    return "R3";
            3:       return "R3";
            4, 5:    return "R7";
            6:       return "R10";
            7:       return "R4";
            8, 9:    return "R2";
            10, 11:  return "R6";
            12:      return "R3";
            13, 14:  return "R5";
            15, 16:  return "R7";
            default: return "R4";
        endcase
    endfunction

    logic            clk = 1'b0;
    logic            rst;
    logic            wr_en;
    logic [DW-1:0]   wr_data;
    logic            rd_addr;
    logic [DW-1:0]   rd_data;
    logic [NIRQ-1:0] irq_req;
    logic [NIRQ-1:0] irq_mask;
    logic            insn_done;
    logic            core_ce;

    int n_run  = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    ccg_top #(.NIRQ(NIRQ), .DW(DW), .STOP_BIT(STOP_BIT)) u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq_req   (irq_req),
        .irq_mask  (irq_mask),
        .insn_done (insn_done),
        .core_ce   (core_ce)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic s, input logic [7:0] irq,
                         input logic [7:0] msk, input logic dn);
        logic [DW-1:0] one_hot;
        @(negedge clk);
        one_hot   = DW'(32'd1 << STOP_BIT);
        wr_en     = w;
        wr_data   = s ? one_hot : ~one_hot;
        irq_req   = irq;
        irq_mask  = msk;
        insn_done = dn;
        @(posedge clk);
        #1;
    endtask

    task automatic check_status(input string req, input logic exp_ce);
        rd_addr = 1'b1;
        #1;
        check(req, rd_data, {{(DW-1){1'b0}}, exp_ce});
        rd_addr = 1'b0;
        #1;
        check("R8", rd_data, '0);
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; rd_addr = 1'b0;
        irq_req = '0; irq_mask = '0; insn_done = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", {31'd0, core_ce}, 32'd1);
        check_status("R9", 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][19], VEC[i][18], VEC[i][17:10], VEC[i][9:2], VEC[i][1]);
            check(tag_of(i), {31'd0, core_ce}, {31'd0, VEC[i][0]});
            check_status("R9", VEC[i][0]);
        end

        // Stop, then reset while idle: enable must come back (R1)
        drive(1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
        drive(1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
        check("R3", {31'd0, core_ce}, 32'd0);
        @(negedge clk);
        rst = 1'b1;
        insn_done = 1'b0;
        @(posedge clk);
        #1;
        check("R1", {31'd0, core_ce}, 32'd1);
        @(negedge clk);
        rst = 1'b0;
        // No pending request survives reset (R1)
        drive(1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
        check("R1", {31'd0, core_ce}, 32'd1);

        // Write with every bit set except the stop bit is ignored (R2)
        drive(1'b1, 1'b0, 8'h00, 8'h00, 1'b0);
        drive(1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
        check("R2", {31'd0, core_ce}, 32'd1);
        check_status("R9", 1'b1);

        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule